// File: doc/BRIEF.md
# Recent Branch History Buffer

The block is an on-chip trace store that keeps a rolling window of the last eight taken branches. Each entry holds the address the branch came from and the address it went to. When a ninth branch is captured, the oldest entry is replaced.

A core-side strobe presents each branch together with three qualifiers: a branch kind, a zero-displacement flag and a completion-exception flag. A filter drops the branch kinds that carry no useful trace information. For completion-type exceptions it moves the recorded source to the next instruction.

A debugger reads entries through an index port. Index 0 is always the newest entry. A saturating count output tells the debugger how many entries are valid. Capture stops while the enable input is low, which is the case when the breakpoint hardware is handed to the user program. A synchronous clear empties the buffer.

Top module: `branch_hist_buf`

## Requirements
- R1: After reset `count_o` is 0 and `rd_vld_o` is low for every index.
- R2: A recorded branch (`br_valid_i` high at a rising edge) is visible from the next cycle at read index 0, with `rd_src_o` and `rd_dst_o` holding its source and destination, and `count_o` has risen by one.
- R3: `count_o` saturates at 8. A further recorded branch overwrites the oldest entry, so index 7 then returns the eighth-newest branch.
- R4: Read index k returns the k-th newest recorded branch (k=0 newest). For k >= `count_o`, `rd_vld_o` is low and both address outputs are 0.
- R5: A branch of kind 1 (conditional, true or false) with `br_disp_zero_i` high is not recorded. A kind 1 branch with `br_disp_zero_i` low is recorded.
- R6: A branch of kind 3 (the reset branch to the reset vector 0xA0000000) is never recorded.
- R7: A branch of kind 2 (exception) with `exc_cmpl_i` high records source `br_src_i`+2, the address after the faulting instruction. With `exc_cmpl_i` low it records `br_src_i` unchanged. Kind 0 is a plain branch and is recorded as presented.
- R8: While `cap_en_i` is low, no branch is recorded and the contents and count are unchanged.
- R9: `clr_i` high at a rising edge empties the buffer, so `count_o` becomes 0. It takes priority over a branch presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clr_i | input | 1 | Synchronous clear of all entries |
| cap_en_i | input | 1 | Capture enable; low while breakpoint hardware belongs to the user program |
| br_valid_i | input | 1 | Branch strobe |
| br_kind_i | input | 2 | Branch kind: 0 plain, 1 conditional, 2 exception, 3 reset |
| br_disp_zero_i | input | 1 | Conditional branch has a zero displacement |
| exc_cmpl_i | input | 1 | Exception is of completion type |
| br_src_i | input | 32 | Branch source address |
| br_dst_i | input | 32 | Branch destination address |
| rd_idx_i | input | 3 | Read index, 0 = newest |
| rd_vld_o | output | 1 | Indexed entry holds a recorded branch |
| rd_src_o | output | 32 | Source address of the indexed entry |
| rd_dst_o | output | 32 | Destination address of the indexed entry |
| count_o | output | 4 | Number of valid entries, saturating at 8 |

## Verification
The bench pushes twelve branches so that the window wraps. A design that fails to overwrite the oldest entry, or that lets the count pass 8, returns stale data at index 7 or shows a wrong count. Dropped kinds are checked by reading every index afterwards. A filter that leaks zero-displacement or reset branches shifts all older entries down by one. The completion exception is checked for the +2 source, and a clear is issued together with a branch. A design that gives the branch priority there is left with count 1 instead of 0.

// File: rtl/bhb_pkg.sv
package bhb_pkg;
  typedef enum logic [1:0] {
    BK_PLAIN = 2'd0,
    BK_COND  = 2'd1,
    BK_EXC   = 2'd2,
    BK_RST   = 2'd3
  } br_kind_e;
endpackage

// File: rtl/bhb_qualify.sv
module bhb_qualify
  import bhb_pkg::*;
#(
  parameter int AW         = 32,
  parameter int INSN_BYTES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_en_i,
  input  logic          br_valid_i,
  input  br_kind_e      br_kind_i,
  input  logic          br_disp_zero_i,
  input  logic          exc_cmpl_i,
  input  logic [AW-1:0] br_src_i,
  output logic          push_o,
  output logic [AW-1:0] src_o
);
  logic drop;

  always_comb begin
    drop = 1'b0;
    unique case (br_kind_i)
      BK_COND: drop = br_disp_zero_i;
      BK_RST:  drop = 1'b1;
      default: drop = 1'b0;
    endcase
  end

  assign push_o = cap_en_i && br_valid_i && !drop;
  // completion exception: report the instruction after the faulting one
  assign src_o  = (br_kind_i == BK_EXC && exc_cmpl_i) ? br_src_i + AW'(INSN_BYTES) : br_src_i;

  p_drop_zero_disp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_kind_i == BK_COND && br_disp_zero_i) |-> !push_o);
  p_no_reset_branch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_kind_i == BK_RST) |-> !push_o);
  p_gate_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_en_i |-> !push_o);
endmodule

// File: rtl/bhb_store.sv
module bhb_store #(
  parameter int AW    = 32,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [PW-1:0] slot_i,
  output logic [AW-1:0] slot_src_o,
  output logic [AW-1:0] slot_dst_o,
  output logic [PW-1:0] wr_ptr_o,
  output logic [CW-1:0] cnt_o
);
  logic [AW-1:0] src_q [DEPTH];
  logic [AW-1:0] dst_q [DEPTH];
  logic [PW-1:0] wr_ptr_q;
  logic [CW-1:0] cnt_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        src_q[g] <= '0;
        dst_q[g] <= '0;
      end else if (!clr_i && push_i && wr_ptr_q == PW'(g)) begin
        src_q[g] <= src_i;
        dst_q[g] <= dst_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (push_i) begin
      wr_ptr_q <= wr_ptr_q + 1'b1;
      if (cnt_q != CW'(DEPTH)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign slot_src_o = src_q[slot_i];
  assign slot_dst_o = dst_q[slot_i];
  assign wr_ptr_o   = wr_ptr_q;
  assign cnt_o      = cnt_q;

  p_cnt_max_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  p_cnt_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && push_i && cnt_q < CW'(DEPTH)) |=> cnt_q == $past(cnt_q) + 1'b1);
  p_clr_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0 && wr_ptr_q == '0));
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !push_i) |=> ($stable(cnt_q) && $stable(wr_ptr_q)));
endmodule

// File: rtl/bhb_read.sv
module bhb_read #(
  parameter int AW    = 32,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] rd_idx_i,
  input  logic [PW-1:0] wr_ptr_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [AW-1:0] slot_src_i,
  input  logic [AW-1:0] slot_dst_i,
  output logic [PW-1:0] slot_o,
  output logic          rd_vld_o,
  output logic [AW-1:0] rd_src_o,
  output logic [AW-1:0] rd_dst_o
);
  // newest entry sits just below the write pointer
  assign slot_o   = wr_ptr_i - PW'(1) - rd_idx_i;
  assign rd_vld_o = CW'(rd_idx_i) < cnt_i;
  assign rd_src_o = rd_vld_o ? slot_src_i : '0;
  assign rd_dst_o = rd_vld_o ? slot_dst_i : '0;

  p_empty_reads_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == '0) |-> (!rd_vld_o && rd_src_o == '0 && rd_dst_o == '0));
  p_full_all_valid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == CW'(DEPTH)) |-> rd_vld_o);
endmodule

// File: rtl/branch_hist_buf.sv
module branch_hist_buf
  import bhb_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DEPTH      = 8,
  parameter int INSN_BYTES = 2,
  localparam int PW        = $clog2(DEPTH),
  localparam int CW        = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          cap_en_i,
  input  logic          br_valid_i,
  input  logic [1:0]    br_kind_i,
  input  logic          br_disp_zero_i,
  input  logic          exc_cmpl_i,
  input  logic [AW-1:0] br_src_i,
  input  logic [AW-1:0] br_dst_i,
  input  logic [PW-1:0] rd_idx_i,
  output logic          rd_vld_o,
  output logic [AW-1:0] rd_src_o,
  output logic [AW-1:0] rd_dst_o,
  output logic [CW-1:0] count_o
);
  logic          push;
  logic [AW-1:0] adj_src;
  logic [PW-1:0] slot, wr_ptr;
  logic [AW-1:0] slot_src, slot_dst;
  logic [CW-1:0] cnt;

  bhb_qualify #(.AW(AW), .INSN_BYTES(INSN_BYTES)) u_qual (
    .clk_i, .rst_ni, .cap_en_i, .br_valid_i,
    .br_kind_i(br_kind_e'(br_kind_i)),
    .br_disp_zero_i, .exc_cmpl_i, .br_src_i,
    .push_o(push), .src_o(adj_src)
  );

  bhb_store #(.AW(AW), .DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni, .clr_i, .push_i(push),
    .src_i(adj_src), .dst_i(br_dst_i), .slot_i(slot),
    .slot_src_o(slot_src), .slot_dst_o(slot_dst),
    .wr_ptr_o(wr_ptr), .cnt_o(cnt)
  );

  bhb_read #(.AW(AW), .DEPTH(DEPTH)) u_read (
    .clk_i, .rst_ni, .rd_idx_i, .wr_ptr_i(wr_ptr), .cnt_i(cnt),
    .slot_src_i(slot_src), .slot_dst_i(slot_dst), .slot_o(slot),
    .rd_vld_o, .rd_src_o, .rd_dst_o
  );

  assign count_o = cnt;

  p_no_clr_growth_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !rd_vld_o);
endmodule

// File: tb/sim_branch_hist_buf.sv
`timescale 1ns/100ps
module sim_branch_hist_buf;
  logic        clk = 0, rst_ni = 0, clr = 0, cap_en = 1, valid = 0, dz = 0, cmpl = 0;
  logic [1:0]  kind = 0;
  logic [31:0] src = 0, dst = 0;
  logic [2:0]  idx = 0;
  logic        vld;
  logic [31:0] rsrc, rdst;
  logic [3:0]  cnt;
  int checks = 0, errors = 0;
  logic [31:0] m_src [8];
  logic [31:0] m_dst [8];
  int m_cnt = 0;

  always #2 clk = ~clk;

  branch_hist_buf u0 (
    .clk_i(clk), .rst_ni, .clr_i(clr), .cap_en_i(cap_en), .br_valid_i(valid),
    .br_kind_i(kind), .br_disp_zero_i(dz), .exc_cmpl_i(cmpl),
    .br_src_i(src), .br_dst_i(dst), .rd_idx_i(idx),
    .rd_vld_o(vld), .rd_src_o(rsrc), .rd_dst_o(rdst), .count_o(cnt)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_push(logic [31:0] s, logic [31:0] d);
    for (int i = 7; i > 0; i--) begin m_src[i] = m_src[i-1]; m_dst[i] = m_dst[i-1]; end
    m_src[0] = s; m_dst[0] = d;
    if (m_cnt < 8) m_cnt++;
  endtask

  // drive one branch for one cycle; rec_src is what the spec says gets stored
  task automatic branch(logic [1:0] k, logic z, logic c, logic [31:0] s, logic [31:0] d,
                        bit rec, logic [31:0] rec_src);
    @(negedge clk);
    valid = 1; kind = k; dz = z; cmpl = c; src = s; dst = d;
    @(negedge clk);
    valid = 0; kind = 0; dz = 0; cmpl = 0;
    if (rec) model_push(rec_src, d);
  endtask

  task automatic check_all(string req);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      idx = 3'(i);
      #1;
      chk(req, 32'(vld), 32'(i < m_cnt));
      chk(req, rsrc, (i < m_cnt) ? m_src[i] : 32'h0);
      chk(req, rdst, (i < m_cnt) ? m_dst[i] : 32'h0);
    end
    chk(req, 32'(cnt), 32'(m_cnt));
  endtask

  task automatic t_reset;
    check_all("R1");
  endtask

  task automatic t_basic;
    branch(0, 0, 0, 32'h0000_1000, 32'h0000_2000, 1, 32'h0000_1000);
    check_all("R2");
    branch(0, 0, 0, 32'h0000_1010, 32'h0000_3000, 1, 32'h0000_1010);
    branch(1, 0, 0, 32'h0000_1020, 32'h0000_1040, 1, 32'h0000_1020);
    check_all("R4");
  endtask

  task automatic t_wrap;
    for (int i = 0; i < 9; i++)
      branch(0, 0, 0, 32'h8000_0000 + 32'(i * 16), 32'h9000_0000 + 32'(i * 4), 1,
             32'h8000_0000 + 32'(i * 16));
    check_all("R3");
  endtask

  task automatic t_filter;
    branch(1, 1, 0, 32'h0000_4000, 32'h0000_4004, 0, 0);
    check_all("R5");
    branch(1, 0, 0, 32'h0000_4100, 32'h0000_4200, 1, 32'h0000_4100);
    branch(3, 0, 0, 32'h0000_5000, 32'hA000_0000, 0, 0);
    check_all("R6");
  endtask

  task automatic t_exc;
    branch(2, 0, 1, 32'h0000_6000, 32'h8C00_0100, 1, 32'h0000_6002);
    check_all("R7");
    branch(2, 0, 0, 32'h0000_6100, 32'h8C00_0400, 1, 32'h0000_6100);
    check_all("R7");
  endtask

  task automatic t_gate;
    @(negedge clk); cap_en = 0;
    branch(0, 0, 0, 32'h0000_7000, 32'h0000_7100, 0, 0);
    check_all("R8");
    @(negedge clk); cap_en = 1;
  endtask

  task automatic t_clear;
    @(negedge clk);
    clr = 1; valid = 1; kind = 0; src = 32'h0000_7700; dst = 32'h0000_7800;
    @(negedge clk);
    clr = 0; valid = 0;
    m_cnt = 0;
    check_all("R9");
    branch(0, 0, 0, 32'h0000_7900, 32'h0000_7A00, 1, 32'h0000_7900);
    check_all("R9");
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin m_src[i] = 0; m_dst[i] = 0; end
    repeat (3) @(negedge clk);
    rst_ni = 1;
    t_reset();
    t_basic();
    t_wrap();
    t_filter();
    t_exc();
    t_gate();
    t_clear();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule